// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Takeover

This block controls an eight-pin general-purpose I/O port through a small word-addressed register bus. The bus has an address, a write strobe, write data and combinational read data. Software owns two registers: an output data register and a direction register. A third register is read-only and holds the pad levels after a two-flop synchroniser. Each pad is modelled as three signals: an output enable, an output level and an input level.

Three kinds of on-chip peripheral can take a pin over: a timer output compare, a routed PWM channel and an external clock output. When a source with authority over a pin is enabled, that source drives the pin as an output with its own level. The software direction bit is not changed by this and still reads back as software wrote it.

Every pin obeys the timer. Only pins 5, 4 and 0 obey the PWM routing. Only pin 5 obeys the clock output. Where several sources apply to one pin, the timer wins over PWM and PWM wins over the clock. When no source claims a pin, the direction bit and the data bit control it.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction and data registers read 0x00, and with no peripheral enabled every pad output enable is 0.
- R2: With no peripheral claiming a pin, pad_oe[i] equals direction bit i and pad_out[i] equals data bit i.
- R3: On every pin, tmr_oc_en[i]=1 forces pad_oe[i]=1 and pad_out[i]=tmr_oc_val[i], and this wins over every other source.
- R4: On pin 5 the order is timer, then PWM (pwm_en[5], pwm_val[5]), then clock output (clk_out_en, clk_out_val), then software.
- R5: On pins 4 and 0 the order is timer, then PWM; clk_out_en has no effect on these pins.
- R6: pwm_en and clk_out_en have no effect on pins 7, 6, 3, 2 and 1.
- R7: A peripheral takeover never changes the direction register; a read returns the last value software wrote.
- R8: A read of the input register returns pad_in regardless of direction. A pad change made before clock edge k is visible after edge k+1 and not after edge k.
- R9: Writes to the input register address are ignored. Reads of an unmapped address (3 to 15) return 0x00. Writes there change no register.
- R10: Word offset 0 is the data register, offset 1 is the input register and offset 2 is the direction register. Data and direction can be written and read back at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Word offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tmr_oc_en | input | 8 | Timer output compare enable, per pin |
| tmr_oc_val | input | 8 | Timer output compare level, per pin |
| pwm_en | input | 8 | Routed PWM channel enable, per pin |
| pwm_val | input | 8 | Routed PWM level, per pin |
| clk_out_en | input | 1 | External clock output enable |
| clk_out_val | input | 1 | External clock output level |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |

## Verification
The hardest case to set up is pin 5 with all three peripherals enabled at once and driving conflicting levels. The stimulus turns the sources off one at a time, from the highest priority down. At each step the level each source drives differs from the level of the source below it, so the pad shows which source is in control. A second delicate case is the synchroniser latency. The bench changes pad_in at a falling edge and reads the input register after one rising edge and again after two, so an early or late arrival is caught. The bench checks the direction readback while overrides are active, which shows that a takeover did not overwrite the software bit.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_OFS = 0;
    localparam int IN_OFS   = 1;
    localparam int DIR_OFS  = 2;

    typedef enum logic [1:0] {
        SRC_SW  = 2'd0,
        SRC_TMR = 2'd1,
        SRC_PWM = 2'd2,
        SRC_CLK = 2'd3
    } drv_src_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_ovr_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  in_q,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  rdata
);
    localparam logic [AW-1:0] A_DATA = AW'(DATA_OFS);
    localparam logic [AW-1:0] A_IN   = AW'(IN_OFS);
    localparam logic [AW-1:0] A_DIR  = AW'(DIR_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (we) begin
            if (addr == A_DATA) data_q <= wdata;
            if (addr == A_DIR)  dir_q  <= wdata;
        end
    end

    always_comb begin
        if (addr == A_DATA)     rdata = data_q;
        else if (addr == A_IN)  rdata = in_q;
        else if (addr == A_DIR) rdata = dir_q;
        else                    rdata = '0;
    end
endmodule

// File: rtl/gpio_pin_sel.sv
module gpio_pin_sel
    import gpio_ovr_pkg::*;
#(
    parameter bit HAS_PWM = 1'b0,
    parameter bit HAS_CLK = 1'b0
) (
    input  logic dir_bit,
    input  logic data_bit,
    input  logic tmr_en,
    input  logic tmr_val,
    input  logic pwm_en,
    input  logic pwm_val,
    input  logic clk_en,
    input  logic clk_val,
    output logic oe,
    output logic out
);
    drv_src_e src;
    logic pwm_ok;
    logic clk_ok;

    assign pwm_ok = HAS_PWM ? pwm_en : 1'b0;
    assign clk_ok = HAS_CLK ? clk_en : 1'b0;

    always_comb begin
        if (tmr_en)      src = SRC_TMR;
        else if (pwm_ok) src = SRC_PWM;
        else if (clk_ok) src = SRC_CLK;
        else             src = SRC_SW;
    end

    always_comb begin
        unique case (src)
            SRC_TMR: begin oe = 1'b1;    out = tmr_val;  end
            SRC_PWM: begin oe = 1'b1;    out = pwm_val;  end
            SRC_CLK: begin oe = 1'b1;    out = clk_val;  end
            default: begin oe = dir_bit; out = data_bit; end
        endcase
    end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_ovr_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int AW = ADDR_W,
    parameter logic [W-1:0] PWM_PINS = 8'h31,
    parameter logic [W-1:0] CLK_PINS = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  tmr_oc_en,
    input  logic [W-1:0]  tmr_oc_val,
    input  logic [W-1:0]  pwm_en,
    input  logic [W-1:0]  pwm_val,
    input  logic          clk_out_en,
    input  logic          clk_out_val,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_out
);
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] in_q;

    gpio_sync #(.W(W), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_q)
    );

    gpio_regs #(.W(W), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .in_q(in_q), .data_q(data_q), .dir_q(dir_q),
        .rdata(bus_rdata)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_pin_sel #(.HAS_PWM(PWM_PINS[i]), .HAS_CLK(CLK_PINS[i])) sel_i (
            .dir_bit(dir_q[i]), .data_bit(data_q[i]),
            .tmr_en(tmr_oc_en[i]), .tmr_val(tmr_oc_val[i]),
            .pwm_en(pwm_en[i]), .pwm_val(pwm_val[i]),
            .clk_en(clk_out_en), .clk_val(clk_out_val),
            .oe(pad_oe[i]), .out(pad_out[i])
        );
    end
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk
    import gpio_ovr_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int AW = ADDR_W,
    parameter logic [W-1:0] PWM_PINS = 8'h31,
    parameter logic [W-1:0] CLK_PINS = 8'h20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  tmr_oc_en,
    input logic [W-1:0]  tmr_oc_val,
    input logic [W-1:0]  pwm_en,
    input logic [W-1:0]  pwm_val,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  pad_out,
    input logic [W-1:0]  dir_q
);
    localparam logic [W-1:0] PLAIN_PINS = ~(PWM_PINS | CLK_PINS);
    localparam logic [AW-1:0] A_DIR = AW'(DIR_OFS);

    // R3: the timer takes over every pin it enables
    assert_tmr_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & tmr_oc_en) == tmr_oc_en) &&
        (((pad_out ^ tmr_oc_val) & tmr_oc_en) == '0));

    // R4: pin 5 follows the PWM level when the timer is off
    assert_p5_pwm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_oc_en[5] && pwm_en[5]) |-> (pad_oe[5] && pad_out[5] == pwm_val[5]));

    // R6: pins without an alternate source are driven only by the timer or software
    assert_plain_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~(tmr_oc_en | dir_q) & PLAIN_PINS) == '0);

    // R7: the direction register changes only on a write to its own address
    assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_DIR) |=> $stable(dir_q));

    // R10: a direction write lands on the next edge
    assert_dir_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR) |=> dir_q == $past(bus_wdata));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(
    .W(W), .AW(AW), .PWM_PINS(PWM_PINS), .CLK_PINS(CLK_PINS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .tmr_oc_en(tmr_oc_en), .tmr_oc_val(tmr_oc_val),
    .pwm_en(pwm_en), .pwm_val(pwm_val), .pad_oe(pad_oe), .pad_out(pad_out),
    .dir_q(dir_q)
);

// File: tb/gpio_port_ovr_tb_top.sv
module gpio_port_ovr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tmr_oc_en = '0, tmr_oc_val = '0, pwm_en = '0, pwm_val = '0;
    logic       clk_out_en = 1'b0, clk_out_val = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port_ovr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_oc_en(tmr_oc_en),
        .tmr_oc_val(tmr_oc_val), .pwm_en(pwm_en), .pwm_val(pwm_val),
        .clk_out_en(clk_out_en), .clk_out_val(clk_out_val), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'd2, v); chk("R1 dir", v, 8'h00);
        rd(4'd0, v); chk("R1 data", v, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
    endtask

    task automatic t_software();
        logic [7:0] v;
        wr(4'd2, 8'hA5); wr(4'd0, 8'h3C);
        rd(4'd2, v); chk("R10 dir readback", v, 8'hA5);
        rd(4'd0, v); chk("R10 data readback", v, 8'h3C);
        chk("R2 oe", pad_oe, 8'hA5);
        chk("R2 out", pad_out, 8'h3C);
        wr(4'd2, 8'h00); wr(4'd0, 8'h00);
    endtask

    task automatic t_timer();
        logic [7:0] v;
        wr(4'd2, 8'h0F);
        @(negedge clk);
        pwm_en = 8'hFF; pwm_val = 8'hFF; clk_out_en = 1; clk_out_val = 1;
        tmr_oc_en = 8'hFF; tmr_oc_val = 8'h5A;
        #1;
        chk("R3 oe", pad_oe, 8'hFF);
        chk("R3 out", pad_out, 8'h5A);
        @(negedge clk);
        rd(4'd2, v); chk("R7 dir kept under override", v, 8'h0F);
        tmr_oc_en = 0; pwm_en = 0; clk_out_en = 0; clk_out_val = 0;
        wr(4'd2, 8'h00);
    endtask

    task automatic t_pin5_chain();
        @(negedge clk);
        tmr_oc_en = 8'h20; tmr_oc_val = 8'h00;
        pwm_en = 8'h20; pwm_val = 8'h20; clk_out_en = 1; clk_out_val = 0;
        #1; chk("R4 timer wins on pin5", {pad_oe[5], pad_out[5]}, 8'h02);
        tmr_oc_en = 0;
        #1; chk("R4 pwm beats clock on pin5", {pad_oe[5], pad_out[5]}, 8'h03);
        pwm_en = 0;
        #1; chk("R4 clock on pin5", {pad_oe[5], pad_out[5]}, 8'h02);
        clk_out_val = 1;
        #1; chk("R4 clock level pin5", pad_out & 8'h20, 8'h20);
        clk_out_en = 0;
        #1; chk("R4 software on pin5", pad_oe, 8'h00);
    endtask

    task automatic t_alt_masks();
        @(negedge clk);
        pwm_en = 8'hFF; pwm_val = 8'hFF;
        #1; chk("R5 pwm on pins 5,4,0", pad_oe, 8'h31);
        chk("R5 pwm level", pad_out, 8'h31);
        pwm_en = 8'hCE;
        #1; chk("R6 pwm ignored on plain pins", pad_oe, 8'h00);
        pwm_en = 0; clk_out_en = 1; clk_out_val = 1;
        #1; chk("R5 R6 clock only on pin5", pad_oe, 8'h20);
        tmr_oc_en = 8'h11; tmr_oc_val = 8'h00; pwm_en = 8'h11;
        #1; chk("R5 timer beats pwm on pins 4,0", pad_out & 8'h11, 8'h00);
        tmr_oc_en = 0; pwm_en = 0; pwm_val = 0; clk_out_en = 0; clk_out_val = 0;
    endtask

    task automatic t_input();
        logic [7:0] v;
        wr(4'd2, 8'hFF);
        pad_in = 8'hC3;
        @(negedge clk);
        rd(4'd1, v); chk("R8 not yet after one edge", v, 8'h00);
        @(negedge clk);
        rd(4'd1, v); chk("R8 visible after two edges", v, 8'hC3);
        wr(4'd2, 8'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        wr(4'd2, 8'h66); wr(4'd0, 8'h99);
        wr(4'd1, 8'h00);
        rd(4'd1, v); chk("R9 input write ignored", v, 8'hC3);
        wr(4'd3, 8'hFF); wr(4'd15, 8'hFF);
        rd(4'd3, v); chk("R9 unmapped read", v, 8'h00);
        rd(4'd2, v); chk("R9 dir untouched", v, 8'h66);
        rd(4'd0, v); chk("R9 data untouched", v, 8'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_software();
        t_timer();
        t_pin5_chain();
        t_alt_masks();
        t_input();
        t_ignored();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule